// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block manages sixteen general-purpose pins through a small 32-bit register bus. Each request is one cycle wide and is marked by a valid strobe, a write flag, a word address and write data. Read data is combinational from the register state during the request cycle.

For each pin, software chooses the following:
- whether the pin is handed to an alternate function (bypass);
- whether it is an input or an output;
- whether its driver is enabled, and the level it drives.

Each pin's incoming level passes through a two-stage synchronizer. The synchronized level can be read back.

Each pin also feeds an interrupt detector, configured per pin:
- level or edge detection;
- active-high/rising or active-low/falling polarity;
- an any-edge option.

Detected events are latched in a sticky status register. Reading that register clears it. Writing ones to it re-injects events. A mask register is changed only through separate write-one-to-set and write-one-to-clear addresses. One interrupt line is high whenever a pending status bit is unmasked.

Word address map:

| Address | Register | Access |
|---|---|---|
| 0 | bypass | read/write |
| 1 | direction | read/write |
| 2 | drive enable | read/write |
| 3 | drive level | read/write |
| 4 | input | read-only |
| 5 | mask | read-only |
| 6 | mask set | write-one-to-set, reads the mask |
| 7 | mask clear | write-one-to-clear, reads the mask |
| 8 | status | read clears, write-one-to-set |
| 9 | detect type | read/write |
| 10 | polarity | read/write |
| 11 | any-edge | read/write |

Every register uses bits 15:0, bit i for pin i. Upper read bits are zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, registers read as follows:
  - bypass, drive enable, drive level, status, detect type, polarity and any-edge all read 0;
  - direction reads 0xFFFF (all inputs);
  - mask reads 0xFFFF (all masked);
  - irq_out and pin_oe are 0.
- R2: pin_alt_sel equals the bypass register. pin_out equals the drive-level register. pin_oe[i] is 1 only when direction[i]=0 (output), drive enable[i]=1 and bypass[i]=0. Write data bits 31:16 are ignored.
- R3: The input register returns pin_in through two flops. A change made between clock edges is visible in a read issued after the second following rising edge, and not after the first.
- R4: Writing address 6 sets the mask bits written as 1. Writing address 7 clears the mask bits written as 1. Bits written as 0 keep their value. A write to address 5 has no effect.
- R5: With detect type bit = 1 (level), a status bit is latched while the synchronized pin equals the polarity bit. It is latched at the third rising edge after the pin change.
- R6: With detect type bit = 0 (edge) and any-edge = 0, polarity 1 latches on rising edges only and polarity 0 on falling edges only.
- R7: With edge detection and any-edge = 1, both edges latch regardless of polarity.
- R8: Status bits remain set until the status register is read; the read returns the old value and clears it. The clear does not apply to these cases:
  - a level source still active stays set;
  - an event detected in the same cycle as the clearing read is kept.
- R9: Writing the status address sets the status bits written as 1. Bits written as 0 are unchanged.
- R10: irq_out is 1 exactly when some status bit is set whose mask bit is 0.
- R11: Unmapped addresses (12 to 15) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current request |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Levels to drive |
| pin_oe | output | 16 | Per-pin driver enable |
| pin_alt_sel | output | 16 | Per-pin alternate-function select |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two functions can act in the same cycle:
- a clearing read of the status register;
- the latching of a freshly detected edge.

The bench provokes this by raising a pin so that its synchronized edge reaches the status register on exactly the rising edge that completes a status read. It then judges the result twice:
- the read must return the bit still clear;
- the following read must return it set, showing the new event was not swallowed by the clear.

The same reasoning covers a level source that is active while it is read: the clear and the re-latch meet, and the bit must survive.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int N  = 16,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic [N-1:0]  pin_alt_sel,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_ALT  = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_OE   = AW'(2);
  localparam logic [AW-1:0] A_OUT  = AW'(3);
  localparam logic [AW-1:0] A_IN   = AW'(4);
  localparam logic [AW-1:0] A_MASK = AW'(5);
  localparam logic [AW-1:0] A_MSET = AW'(6);
  localparam logic [AW-1:0] A_MCLR = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [AW-1:0] A_TYPE = AW'(9);
  localparam logic [AW-1:0] A_POL  = AW'(10);
  localparam logic [AW-1:0] A_ANY  = AW'(11);

  logic [N-1:0] alt_q, dir_q, oe_q, out_q, mask_q, stat_q, typ_q, pol_q, any_q;
  logic [N-1:0] s1_q, s2_q, s3_q;
  logic [N-1:0] wd, rise, fall, lvl_hit, edge_hit, hit, stat_d;
  logic         wr, rd;
  logic         unused_hi;

  assign wr        = bus_valid & bus_write;
  assign rd        = bus_valid & ~bus_write;
  assign wd        = bus_wdata[N-1:0];
  assign unused_hi = ^bus_wdata[DW-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise     = s2_q & ~s3_q;
  assign fall     = ~s2_q & s3_q;
  assign lvl_hit  = typ_q & ~(s2_q ^ pol_q);
  assign edge_hit = ~typ_q & ((any_q & (rise | fall)) |
                              (~any_q & pol_q & rise) |
                              (~any_q & ~pol_q & fall));
  assign hit      = lvl_hit | edge_hit;

  assign stat_d = ((rd && bus_addr == A_STAT) ? '0 : stat_q) | hit |
                  ((wr && bus_addr == A_STAT) ? wd : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= '0;
      dir_q  <= '1;
      oe_q   <= '0;
      out_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      typ_q  <= '0;
      pol_q  <= '0;
      any_q  <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr) begin
        case (bus_addr)
          A_ALT:   alt_q  <= wd;
          A_DIR:   dir_q  <= wd;
          A_OE:    oe_q   <= wd;
          A_OUT:   out_q  <= wd;
          A_MSET:  mask_q <= mask_q | wd;
          A_MCLR:  mask_q <= mask_q & ~wd;
          A_TYPE:  typ_q  <= wd;
          A_POL:   pol_q  <= wd;
          A_ANY:   any_q  <= wd;
          default: ;
        endcase
      end
    end
  end

  logic [N-1:0] rsel;
  always_comb begin
    case (bus_addr)
      A_ALT:                 rsel = alt_q;
      A_DIR:                 rsel = dir_q;
      A_OE:                  rsel = oe_q;
      A_OUT:                 rsel = out_q;
      A_IN:                  rsel = s2_q;
      A_MASK, A_MSET, A_MCLR: rsel = mask_q;
      A_STAT:                rsel = stat_q;
      A_TYPE:                rsel = typ_q;
      A_POL:                 rsel = pol_q;
      A_ANY:                 rsel = any_q;
      default:               rsel = '0;
    endcase
  end
  assign bus_rdata = {{(DW-N){1'b0}}, rsel};

  assign pin_out     = out_q;
  assign pin_alt_sel = alt_q;
  assign pin_oe      = oe_q & ~dir_q & ~alt_q;
  assign irq_out     = |(stat_q & ~mask_q);

  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_MSET) |=> ((mask_q & $past(wd)) == $past(wd)));
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_MCLR) |=> ((mask_q & $past(wd)) == '0));
  a_r4_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_MASK) |=> $stable(mask_q));
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && bus_addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r9_write_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == A_STAT) |=> ((stat_q & $past(wd)) == $past(wd)));
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (stat_q != '0));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_alt_sel;
  logic        irq_out;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_alt_sel(pin_alt_sel), .irq_out(irq_out)
  );

  // {write, addr, data (expected on reads), requirement}
  localparam int NV = 30;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 4'd0,  32'h0000_0000, 4'd1},  // R1 reset values
    {1'b0, 4'd1,  32'h0000_FFFF, 4'd1},
    {1'b0, 4'd2,  32'h0000_0000, 4'd1},
    {1'b0, 4'd3,  32'h0000_0000, 4'd1},
    {1'b0, 4'd5,  32'h0000_FFFF, 4'd1},
    {1'b0, 4'd8,  32'h0000_0000, 4'd1},
    {1'b0, 4'd9,  32'h0000_0000, 4'd1},
    {1'b0, 4'd10, 32'h0000_0000, 4'd1},
    {1'b0, 4'd11, 32'h0000_0000, 4'd1},
    {1'b1, 4'd0,  32'hABCD_00A5, 4'd2},  // R2 pin control
    {1'b0, 4'd0,  32'h0000_00A5, 4'd2},
    {1'b1, 4'd1,  32'h0000_0F0F, 4'd2},
    {1'b0, 4'd1,  32'h0000_0F0F, 4'd2},
    {1'b1, 4'd2,  32'h0000_FFFF, 4'd2},
    {1'b1, 4'd3,  32'h0000_1234, 4'd2},
    {1'b0, 4'd3,  32'h0000_1234, 4'd2},
    {1'b1, 4'd7,  32'h0000_00FF, 4'd4},  // R4 mask aliases
    {1'b0, 4'd5,  32'h0000_FF00, 4'd4},
    {1'b1, 4'd6,  32'h0000_0003, 4'd4},
    {1'b0, 4'd6,  32'h0000_FF03, 4'd4},
    {1'b1, 4'd5,  32'h0000_0000, 4'd4},
    {1'b0, 4'd7,  32'h0000_FF03, 4'd4},
    {1'b0, 4'd12, 32'h0000_0000, 4'd11}, // R11 unmapped
    {1'b0, 4'd15, 32'h0000_0000, 4'd11},
    {1'b1, 4'd9,  32'h0000_5555, 4'd5},
    {1'b0, 4'd9,  32'h0000_5555, 4'd5},
    {1'b1, 4'd10, 32'h0000_3C3C, 4'd6},
    {1'b0, 4'd10, 32'h0000_3C3C, 4'd6},
    {1'b1, 4'd11, 32'h0000_0F00, 4'd7},
    {1'b0, 4'd11, 32'h0000_0F00, 4'd7}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    bus(1'b0, a, 32'h0, q);
  endtask

  task automatic do_reset;
    pin_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    do_reset();
    #1;
    check("R1 irq_out", {31'd0, irq_out}, 32'd0);
    check("R1 pin_oe", {16'd0, pin_oe}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] got;
      bus(VEC[i][40], VEC[i][39:36], VEC[i][35:4], got);
      if (!VEC[i][40])
        check($sformatf("R%0d table %0d", VEC[i][3:0], i), got, VEC[i][35:4]);
    end
    check("R2 pin_oe", {16'd0, pin_oe}, 32'h0000_F050);
    check("R2 pin_out", {16'd0, pin_out}, 32'h0000_1234);
    check("R2 pin_alt_sel", {16'd0, pin_alt_sel}, 32'h0000_00A5);

    do_reset();
    wr(4'd9, 32'h0001);
    wr(4'd10, 32'h0063);
    wr(4'd11, 32'h0008);
    wr(4'd7, 32'h004F);
    rd(4'd8, q);

    // R5 level-high on pin 0
    @(negedge clk) pin_in[0] = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R10 irq on unmasked level", {31'd0, irq_out}, 32'd1);
    rd(4'd8, q); check("R5 level latched", q, 32'h0001);
    rd(4'd8, q); check("R8 level re-latches after clear", q, 32'h0001);
    @(negedge clk) pin_in[0] = 1'b0;
    repeat (4) @(posedge clk);
    rd(4'd8, q);
    rd(4'd8, q); check("R5 inactive level clears", q, 32'h0000);
    #1 check("R10 irq low when clear", {31'd0, irq_out}, 32'd0);

    // R6 rising on pin 1
    @(negedge clk) pin_in[1] = 1'b1;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R6 rising edge", q, 32'h0002);
    rd(4'd8, q); check("R8 edge not re-latched", q, 32'h0000);
    @(negedge clk) pin_in[1] = 1'b0;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R6 falling ignored with rising polarity", q, 32'h0000);

    // R6 falling on pin 2
    @(negedge clk) pin_in[2] = 1'b1;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R6 rising ignored with falling polarity", q, 32'h0000);
    @(negedge clk) pin_in[2] = 1'b0;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R6 falling edge", q, 32'h0004);

    // R7 any-edge on pin 3 (polarity 0)
    @(negedge clk) pin_in[3] = 1'b1;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R7 any-edge rising", q, 32'h0008);
    @(negedge clk) pin_in[3] = 1'b0;
    repeat (4) @(posedge clk);
    rd(4'd8, q); check("R7 any-edge falling", q, 32'h0008);

    // R10 / R4 masking on pin 5
    @(negedge clk) pin_in[5] = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R10 masked source silent", {31'd0, irq_out}, 32'd0);
    wr(4'd7, 32'h0020);
    check("R10 unmask raises irq", {31'd0, irq_out}, 32'd1);
    wr(4'd6, 32'h0020);
    check("R4 mask set lowers irq", {31'd0, irq_out}, 32'd0);
    rd(4'd8, q); check("R8 sticky while masked", q, 32'h0020);

    // R9 write-one-to-set
    wr(4'd8, 32'h8000);
    rd(4'd8, q); check("R9 status write sets", q, 32'h8000);
    wr(4'd8, 32'h0000);
    rd(4'd8, q); check("R9 zero write leaves status", q, 32'h0000);

    // R8 clearing read meets a new edge on pin 6
    @(negedge clk) pin_in[6] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    rd(4'd8, q); check("R8 read in latch cycle returns old", q, 32'h0000);
    rd(4'd8, q); check("R8 event kept across clear", q, 32'h0040);

    // R3 synchronizer depth
    @(negedge clk) pin_in[15:8] = 8'hA5;
    @(posedge clk);
    rd(4'd4, q); check("R3 not visible after one edge", q, 32'h0060);
    rd(4'd4, q); check("R3 visible after two edges", q, 32'hA560);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule